// File: doc/BRIEF.md
# I/O-Port Bulk Row Receiver

This block listens to an 8-bit ISA-style I/O bus on which a host streams display frames as repeated DMA block writes to one fixed port. Each write strobe whose upper address bits hit the port pattern delivers one data byte. The block groups the bytes into rows of 32 bytes, which is 128 pixels at 2 bits each. It writes every pixel byte into a frame buffer at the address row*32+column. A terminal-count pulse closes each row, and 48 rows form a frame.

Between row blocks the host sends a few control bytes: a start-of-frame sequence and some mid-frame pairs. While no row is open, the block drops these bytes. If a row closes before it holds 32 bytes, the block fills the rest of the row with zeros and raises a sticky error flag. When the last row closes, the block pulses a frame-complete strobe for one clock and starts again at row 0.

The bus inputs are asynchronous to the local clock. They pass through a two-stage synchronizer before the block detects edges on them.

Top module: `isa_row_rx`

## Requirements
- R1: A byte is accepted only when addr_i (address bits 9..2) equals 8'hBC, which covers I/O port 0x2F0 to 0x2F3. Strobes at any other address write nothing.
- R2: A byte is taken once per falling edge of iow_ni. Holding iow_ni low for a long time takes a single byte.
- R3: While no row is open, the bytes 8'h8F, 8'h0F, 8'h07, 8'h05 and 8'h06 are dropped. The first byte with any other value opens a row and is stored at column 0.
- R4: Inside an open row, every accepted byte is stored at the next column, including bytes that have control values. The buffer write shows wr_en_o high, wr_addr_o = row*32 + column and wr_data_o = the byte.
- R5: Bytes that arrive after 32 bytes have been stored in the current row, and before terminal count, are dropped.
- R6: A rising edge of tc_i closes the open row and row_o advances by one.
- R7: If terminal count closes a row that holds fewer than 32 bytes, the remaining columns are written with 8'h00. err_o is then set and stays set until reset.
- R8: When row 47 closes, frame_valid_o is high for exactly one clock and row_o returns to 0. The next row is written starting at buffer address 0.
- R9: A terminal-count edge while no row is open has no effect on row_o.
- R10: After reset, row_o = 0 and frame_valid_o, err_o and wr_en_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Bus address bits 9..2 |
| data_i | input | 8 | Bus data byte |
| iow_ni | input | 1 | Active-low I/O write strobe |
| tc_i | input | 1 | Terminal-count pulse, active high |
| wr_en_o | output | 1 | Frame buffer write enable |
| wr_addr_o | output | 11 | Frame buffer byte address |
| wr_data_o | output | 8 | Frame buffer write data |
| row_o | output | 6 | Index of the row being received |
| frame_valid_o | output | 1 | One-clock pulse when a frame is complete |
| err_o | output | 1 | Sticky flag for a short row |

## Verification
The assertions assume slow bus strobes. Strobe edges must be many local clocks apart, so two pixel writes never land on adjacent cycles, and the zero fill of a short row must finish before the next strobe arrives. Under these assumptions, two back-to-back writes can only come from the zero fill. The bench holds address and data steady for two cycles before each strobe falls. It keeps each strobe low for at least six cycles and high for six, and it waits forty cycles after each terminal-count pulse. This spacing keeps the stimulus inside those assumptions.

// File: rtl/isa_rx_pkg.sv
package isa_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROW,
    ST_FILL
  } rx_state_e;

  // bytes that may appear between row blocks
  function automatic logic is_ctrl_byte(input logic [7:0] b);
    return (b == 8'h8F) || (b == 8'h0F) || (b == 8'h07) ||
           (b == 8'h05) || (b == 8'h06);
  endfunction
endpackage

// File: rtl/isa_rx_sync.sv
module isa_rx_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/isa_rx_front.sv
module isa_rx_front #(
  parameter logic [7:0]  MATCH_PAT   = 8'hBC,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  input  logic [7:0] data_i,
  input  logic       iow_ni,
  input  logic       tc_i,
  output logic       byte_ev_o,
  output logic [7:0] byte_o,
  output logic       tc_ev_o
);
  localparam int unsigned SW = 18;
  localparam logic [SW-1:0] SYNC_RST = {8'h00, 8'h00, 1'b1, 1'b0};

  logic [SW-1:0] sync_q;
  logic [7:0]    addr_s, data_s;
  logic          iow_s, tc_s;
  logic          iow_q, tc_q;

  isa_rx_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({addr_i, data_i, iow_ni, tc_i}),
    .q_o   (sync_q)
  );

  assign {addr_s, data_s, iow_s, tc_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iow_q <= 1'b1;
      tc_q  <= 1'b0;
    end else begin
      iow_q <= iow_s;
      tc_q  <= tc_s;
    end
  end

  assign byte_ev_o = (addr_s == MATCH_PAT) && iow_q && !iow_s;
  assign byte_o    = data_s;
  assign tc_ev_o   = tc_s && !tc_q;

  assert_strobe_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ev_o |=> !byte_ev_o);
  assert_tc_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_ev_o |=> !tc_ev_o);
endmodule

// File: rtl/isa_rx_ctrl.sv
module isa_rx_ctrl
  import isa_rx_pkg::*;
#(
  parameter int unsigned ROW_BYTES = 32,
  parameter int unsigned ROWS      = 48,
  localparam int unsigned DEPTH    = ROW_BYTES * ROWS,
  localparam int unsigned ADDR_W   = $clog2(DEPTH),
  localparam int unsigned ROW_W    = $clog2(ROWS),
  localparam int unsigned COL_W    = $clog2(ROW_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_ev_i,
  input  logic [7:0]        byte_i,
  input  logic              tc_ev_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              frame_valid_o,
  output logic              err_o
);
  localparam logic [COL_W-1:0] COL_FULL = COL_W'(ROW_BYTES);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(ROW_BYTES - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  rx_state_e        state_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [ADDR_W-1:0] cur_addr;
  logic             last_row;

  assign cur_addr = ADDR_W'(row_q) * ADDR_W'(ROW_BYTES) + ADDR_W'(col_q);
  assign last_row = (row_q == ROW_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      col_q         <= '0;
      row_q         <= '0;
      wr_en_o       <= 1'b0;
      wr_addr_o     <= '0;
      wr_data_o     <= '0;
      frame_valid_o <= 1'b0;
      err_o         <= 1'b0;
    end else begin
      wr_en_o       <= 1'b0;
      frame_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (byte_ev_i && !is_ctrl_byte(byte_i)) begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= cur_addr;
            wr_data_o <= byte_i;
            col_q     <= COL_W'(1);
            state_q   <= ST_ROW;
          end
        end
        ST_ROW: begin
          if (tc_ev_i) begin
            if (col_q == COL_FULL) begin
              col_q         <= '0;
              state_q       <= ST_IDLE;
              row_q         <= last_row ? '0 : row_q + 1'b1;
              frame_valid_o <= last_row;
            end else begin
              err_o   <= 1'b1;
              state_q <= ST_FILL;
            end
          end else if (byte_ev_i && col_q != COL_FULL) begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= cur_addr;
            wr_data_o <= byte_i;
            col_q     <= col_q + 1'b1;
          end
        end
        ST_FILL: begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= cur_addr;
          wr_data_o <= 8'h00;
          if (col_q == COL_LAST) begin
            col_q         <= '0;
            state_q       <= ST_IDLE;
            row_q         <= last_row ? '0 : row_q + 1'b1;
            frame_valid_o <= last_row;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign row_o = row_q;

  assert_fv_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);
  assert_fv_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> row_o == '0);
  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_fill_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> wr_data_o == 8'h00);
  assert_addr_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_addr_o < ADDR_W'(DEPTH));
  assert_row_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_o <= ROW_LAST);
endmodule

// File: rtl/isa_row_rx.sv
module isa_row_rx #(
  parameter logic [7:0]  MATCH_PAT   = 8'hBC,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ROW_BYTES   = 32,
  parameter int unsigned ROWS        = 48,
  localparam int unsigned ADDR_W     = $clog2(ROW_BYTES * ROWS),
  localparam int unsigned ROW_W      = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic [7:0]        data_i,
  input  logic              iow_ni,
  input  logic              tc_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              frame_valid_o,
  output logic              err_o
);
  logic       byte_ev, tc_ev;
  logic [7:0] byte_d;

  isa_rx_front #(.MATCH_PAT(MATCH_PAT), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .iow_ni   (iow_ni),
    .tc_i     (tc_i),
    .byte_ev_o(byte_ev),
    .byte_o   (byte_d),
    .tc_ev_o  (tc_ev)
  );

  isa_rx_ctrl #(.ROW_BYTES(ROW_BYTES), .ROWS(ROWS)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_ev_i    (byte_ev),
    .byte_i       (byte_d),
    .tc_ev_i      (tc_ev),
    .wr_en_o      (wr_en_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .row_o        (row_o),
    .frame_valid_o(frame_valid_o),
    .err_o        (err_o)
  );
endmodule

// File: tb/sim_isa_row_rx.sv
module sim_isa_row_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  data = 8'h00;
  logic        iow_n = 1'b1;
  logic        tc = 1'b0;
  logic        wr_en;
  logic [10:0] wr_addr;
  logic [7:0]  wr_data;
  logic [5:0]  row;
  logic        fv;
  logic        err;

  int checks = 0;
  int fails = 0;
  int wcnt = 0;
  int fvcnt = 0;
  logic [7:0] bmem [1536];

  localparam logic [7:0] PORT = 8'hBC;   // 0x2F0 >> 2
  localparam logic [7:0] OTHER = 8'hBE;  // 0x2F8 >> 2

  always #2 clk = ~clk;

  isa_row_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data), .iow_ni(iow_n),
    .tc_i(tc), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .row_o(row), .frame_valid_o(fv), .err_o(err)
  );

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      bmem[wr_addr] = wr_data;
      wcnt++;
    end
    if (rst_n && fv) fvcnt++;
  end

  function automatic logic [7:0] exp_byte(input int r, input int c);
    if (c == 0) return 8'(8'hC0 + r);
    if (c == 5) return 8'h07;
    return 8'((r * 7 + c) ^ 8'h5A);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send_byte(input logic [7:0] a, input logic [7:0] d, input int low = 6);
    @(negedge clk);
    addr = a; data = d;
    repeat (2) @(negedge clk);
    iow_n = 1'b0;
    repeat (low) @(negedge clk);
    iow_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_tc();
    @(negedge clk);
    tc = 1'b1;
    repeat (4) @(negedge clk);
    tc = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic send_row(input int r, input int n);
    for (int c = 0; c < n; c++) send_byte(PORT, exp_byte(r, c));
  endtask

  task automatic check_row(input int r, input int n, input string req);
    int bad = 0;
    int first = -1;
    for (int c = 0; c < 32; c++) begin
      logic [7:0] e;
      e = (c < n) ? exp_byte(r, c) : 8'h00;
      if (bmem[r*32+c] !== e) begin
        bad++;
        if (first < 0) first = c;
      end
    end
    if (first < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, bmem[r*32+first], (first < n) ? exp_byte(r, first) : 0);
  endtask

  task automatic t_reset();
    chk(row == 0, "R10 row", row, 0);
    chk(!fv && !err && !wr_en, "R10 flags", {fv, err, wr_en}, 0);
  endtask

  task automatic t_idle_filter();
    send_byte(PORT, 8'h8F);
    send_byte(PORT, 8'h0F);
    send_byte(PORT, 8'h07);
    chk(wcnt == 0, "R3 preamble dropped", wcnt, 0);
    send_byte(OTHER, 8'hAA);
    chk(wcnt == 0, "R1 other port ignored", wcnt, 0);
    pulse_tc();
    chk(row == 0, "R9 idle tc ignored", row, 0);
  endtask

  task automatic t_row0();
    send_row(0, 32);
    chk(wcnt == 32, "R4 row0 count", wcnt, 32);
    check_row(0, 32, "R4 R3 R1 row0 content");
    send_byte(PORT, 8'hEE);
    chk(wcnt == 32, "R5 overflow dropped", wcnt, 32);
    send_byte(OTHER, 8'h33);
    chk(wcnt == 32, "R1 other port in row", wcnt, 32);
    pulse_tc();
    chk(row == 1, "R6 row advance", row, 1);
  endtask

  task automatic t_row1_long();
    send_byte(PORT, 8'h05);
    send_byte(PORT, 8'h07);
    send_byte(PORT, 8'h06);
    chk(wcnt == 32, "R3 mid pairs dropped", wcnt, 32);
    for (int c = 0; c < 32; c++) send_byte(PORT, exp_byte(1, c), (c == 3) ? 60 : 6);
    chk(wcnt == 64, "R2 long strobe one byte", wcnt, 64);
    check_row(1, 32, "R2 row1 content");
    chk(!err, "R7 no err yet", err, 0);
    pulse_tc();
    chk(row == 2, "R6 row2", row, 2);
  endtask

  task automatic t_short_row();
    send_row(2, 10);
    pulse_tc();
    chk(wcnt == 96, "R7 fill count", wcnt, 96);
    check_row(2, 10, "R7 zero fill");
    chk(err, "R7 err set", err, 1);
    chk(row == 3, "R7 row after short", row, 3);
  endtask

  task automatic t_frame_wrap();
    for (int r = 3; r < 48; r++) begin
      send_row(r, 32);
      if (r == 47) chk(fvcnt == 0, "R8 no early frame", fvcnt, 0);
      pulse_tc();
    end
    chk(fvcnt == 1, "R8 single frame pulse", fvcnt, 1);
    chk(row == 0, "R8 row wrap", row, 0);
    check_row(47, 32, "R4 last row content");
    send_byte(PORT, 8'h9D);
    chk(bmem[0] == 8'h9D, "R8 restart at addr 0", bmem[0], 8'h9D);
    chk(err, "R7 err sticky", err, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1536; i++) bmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_idle_filter();
    t_row0();
    t_row1_long();
    t_short_row();
    t_frame_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule